// File: doc/BRIEF.md
# Quadrature X4 Position Counter

This block turns two phase signals and an index pulse from an incremental encoder into a position count. Every edge on either phase moves the count by one, giving four counts per encoder cycle. The order in which the phases change sets the direction of each step. The count runs between zero and a programmable ceiling and wraps at both ends. In index mode, an index edge taken while the phases sit in a chosen state also returns the count to zero. In wrap mode, the index is ignored and only the ceiling bounds the count.

The phase and index inputs are assumed to be filtered and synchronous to `clk` already. All configuration (ceiling, mode, index gating, phase swap and the three polarity bits) is sampled only while `enable` is low. Changes made while the counter runs are held back until it is stopped again. Each step, wrap, index reset and direction reversal is reported on the outputs in the cycle after the input change that caused it.

Top module: `qx4_position`

## Requirements
- R1: Synchronous reset (rst_n low at a clock edge) gives count 0, dir_up 1, all event outputs 0 and phase_err 0.
- R2: Phases are ranked as state {A,B}. With enable high, the up order 00→10→11→01→00 (A leading B) adds one to the count for each single-phase change. The new count appears at the clock edge that first samples the changed input.
- R3: With enable high, each single-phase change in the reverse order (00→01→11→10→00) subtracts one from the count.
- R4: With swap_ab high, A and B trade places before decoding, so the raw input sequence that counts up without swap counts down.
- R5: inv_a and inv_b invert their phase before decoding, so one inverted phase reverses the direction of a given raw sequence. idx_falling high makes a falling index edge the event instead of a rising one.
- R6: With wrap_mode 0, an index event resets the count to 0 only while decoded {A,B} equals idx_gate (bit 1 = A level, bit 0 = B level). The reset pulses evt_reset_up if dir_up is 1 and evt_reset_down otherwise. An index reset takes priority over a phase step in the same cycle.
- R7: With wrap_mode 1, index events never change the count or raise an event.
- R8: A step up from a count at or above the ceiling gives 0 and a one-cycle evt_reset_up. A step down from 0 gives the ceiling and a one-cycle evt_reset_down.
- R9: dir_up follows the direction of the last step. evt_dir_change pulses for one cycle on a step whose direction differs from the previous one.
- R10: A change of both phases in one cycle leaves the count unchanged and sets phase_err, which stays set until reset.
- R11: While enable is low, the count holds, no event is raised and phase_err is not set.
- R12: ceiling, wrap_mode, idx_gate, swap_ab, inv_a, inv_b and idx_falling take effect only if presented while enable is low. Changes while enable is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Counting enable; configuration loads while low |
| swap_ab | input | 1 | Exchange phase A and phase B |
| inv_a | input | 1 | Invert phase A |
| inv_b | input | 1 | Invert phase B |
| idx_falling | input | 1 | Index event on falling edge when high |
| idx_gate | input | 2 | Required {A,B} state for an index event |
| wrap_mode | input | 1 | 1: ceiling wrap only; 0: index reset enabled |
| ceiling | input | CNT_W | Upper count bound |
| phase_a | input | 1 | Phase A |
| phase_b | input | 1 | Phase B |
| index | input | 1 | Index pulse |
| count | output | CNT_W | Position count |
| dir_up | output | 1 | Direction of last step, 1 = up |
| evt_reset_up | output | 1 | One-cycle pulse: wrap or index reset while counting up |
| evt_reset_down | output | 1 | One-cycle pulse: wrap or index reset while counting down |
| evt_dir_change | output | 1 | One-cycle pulse: step direction reversed |
| phase_err | output | 1 | Sticky illegal-transition flag |

## Verification
A wrong previous-phase sample or a wrong direction register shows up at `count` and `dir_up` on the very next edge of the encoder signal, as a step of the wrong sign or a missing step. A ceiling or gating shadow that loads at the wrong time only becomes visible at the next wrap or index event, so the bench drives wraps and gated index pulses right after configuration changes. A lost or stuck event flag appears one cycle after the step that should have raised it.

// File: rtl/qx4_pkg.sv
// Package: shared types and the quadrature transition classifier.
// Assumes phase pairs are packed {A,B} with A in bit 1.
package qx4_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2,
        STEP_ERR  = 2'd3
    } step_e;

    typedef enum logic {
        MODE_INDEX = 1'b0,
        MODE_WRAP  = 1'b1
    } rst_mode_e;

    // Next {A,B} state in the up direction (A leads B).
    function automatic logic [1:0] up_next(input logic [1:0] s);
        case (s)
            2'b00:   up_next = 2'b10;
            2'b10:   up_next = 2'b11;
            2'b11:   up_next = 2'b01;
            default: up_next = 2'b00;
        endcase
    endfunction

    // Classify the move from prev to cur.
    function automatic step_e classify(input logic [1:0] prev, input logic [1:0] cur);
        if (prev == cur)                 classify = STEP_NONE;
        else if ((prev ^ cur) == 2'b11)  classify = STEP_ERR;
        else if (up_next(prev) == cur)   classify = STEP_UP;
        else                             classify = STEP_DN;
    endfunction

endpackage

// File: rtl/qx4_cfg.sv
// Configuration shadow: loads every setting while the counter is stopped
// and freezes all of them while it runs. Assumes enable is synchronous.
module qx4_cfg
    import qx4_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             swap_i,
    input  logic             inv_a_i,
    input  logic             inv_b_i,
    input  logic             idx_fall_i,
    input  logic [1:0]       gate_i,
    input  logic             mode_i,
    input  logic [CNT_W-1:0] ceil_i,
    output logic             swap_q,
    output logic             inv_a_q,
    output logic             inv_b_q,
    output logic             idx_fall_q,
    output logic [1:0]       gate_q,
    output rst_mode_e        mode_q,
    output logic [CNT_W-1:0] ceil_q
);

    // Load settings while stopped, hold while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            swap_q     <= 1'b0;
            inv_a_q    <= 1'b0;
            inv_b_q    <= 1'b0;
            idx_fall_q <= 1'b0;
            gate_q     <= 2'b00;
            mode_q     <= MODE_INDEX;
            ceil_q     <= '1;
        end else if (!en_i) begin
            swap_q     <= swap_i;
            inv_a_q    <= inv_a_i;
            inv_b_q    <= inv_b_i;
            idx_fall_q <= idx_fall_i;
            gate_q     <= gate_i;
            mode_q     <= rst_mode_e'(mode_i);
            ceil_q     <= ceil_i;
        end
    end

    // R12: running counter sees frozen settings
    assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> ($stable(ceil_q) && $stable(mode_q) && $stable(gate_q) && $stable(swap_q)));

endmodule

// File: rtl/qx4_decode.sv
// Phase decoder: applies polarity and swap, compares against the previous
// raw sample (conditioned with the same settings) and flags a gated index
// edge. Assumes inputs are already filtered and synchronous.
module qx4_decode
    import qx4_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       swap_i,
    input  logic       inv_a_i,
    input  logic       inv_b_i,
    input  logic       idx_fall_i,
    input  logic [1:0] gate_i,
    input  logic       pha_i,
    input  logic       phb_i,
    input  logic       idx_i,
    output step_e      step_o,
    output logic       idx_hit_o
);

    localparam int NPH = 2;

    logic [NPH-1:0] raw_c, raw_p, inv_v, pol_c, pol_p;
    logic [1:0]     ab_c, ab_p;
    logic           idx_p, idx_c_pol, idx_p_pol;

    assign raw_c = {pha_i, phb_i};
    assign inv_v = {inv_a_i, inv_b_i};

    // Previous raw sample; reset also captures the pins so no phantom step follows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_p <= raw_c;
            idx_p <= idx_i;
        end else begin
            raw_p <= raw_c;
            idx_p <= idx_i;
        end
    end

    // Per-phase polarity for current and previous samples.
    for (genvar g = 0; g < NPH; g++) begin : g_pol
        assign pol_c[g] = raw_c[g] ^ inv_v[g];
        assign pol_p[g] = raw_p[g] ^ inv_v[g];
    end

    // Swap A and B roles when requested.
    always_comb begin
        ab_c = swap_i ? {pol_c[0], pol_c[1]} : pol_c;
        ab_p = swap_i ? {pol_p[0], pol_p[1]} : pol_p;
    end

    assign step_o    = classify(ab_p, ab_c);
    assign idx_c_pol = idx_i ^ idx_fall_i;
    assign idx_p_pol = idx_p ^ idx_fall_i;
    assign idx_hit_o = idx_c_pol && !idx_p_pol && (ab_c == gate_i);

endmodule

// File: rtl/qx4_count.sv
// Position counter: applies steps within [0, ceiling], performs index
// resets, tracks direction and produces one-cycle event pulses.
// Assumes step and index inputs are valid in the cycle they are presented.
module qx4_count
    import qx4_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  rst_mode_e        mode_i,
    input  logic [CNT_W-1:0] ceil_i,
    input  step_e            step_i,
    input  logic             idx_hit_i,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_o,
    output logic             up_evt_o,
    output logic             dn_evt_o,
    output logic             chg_evt_o,
    output logic             err_o
);

    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             dir_q, dir_n, up_q, up_n, dn_q, dn_n, chg_q, chg_n, err_q, err_n;
    logic             do_idx;

    assign do_idx = en_i && (mode_i == MODE_INDEX) && idx_hit_i;

    // Next-state selection: index reset beats a step; disabled holds.
    always_comb begin
        cnt_n = cnt_q;
        dir_n = dir_q;
        up_n  = 1'b0;
        dn_n  = 1'b0;
        chg_n = 1'b0;
        err_n = err_q || (en_i && step_i == STEP_ERR);
        if (do_idx) begin
            cnt_n = '0;
            up_n  = dir_q;
            dn_n  = !dir_q;
        end else if (en_i && step_i == STEP_UP) begin
            up_n  = (cnt_q >= ceil_i);
            cnt_n = up_n ? '0 : cnt_q + 1'b1;
            dir_n = 1'b1;
            chg_n = !dir_q;
        end else if (en_i && step_i == STEP_DN) begin
            dn_n  = (cnt_q == '0);
            cnt_n = dn_n ? ceil_i : cnt_q - 1'b1;
            dir_n = 1'b0;
            chg_n = dir_q;
        end
    end

    // State and event registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b1;
            up_q  <= 1'b0;
            dn_q  <= 1'b0;
            chg_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            dir_q <= dir_n;
            up_q  <= up_n;
            dn_q  <= dn_n;
            chg_q <= chg_n;
            err_q <= err_n;
        end
    end

    assign count_o   = cnt_q;
    assign dir_o     = dir_q;
    assign up_evt_o  = up_q;
    assign dn_evt_o  = dn_q;
    assign chg_evt_o = chg_q;
    assign err_o     = err_q;

    // R11: stopped counter holds and stays quiet
    assert_hold_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(cnt_q) && !up_q && !dn_q && !chg_q));
    // R10: illegal move never changes the count
    assert_err_no_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && step_i == STEP_ERR && !do_idx) |=> $stable(cnt_q));
    // R10: error flag is sticky
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    // R8: at most one reset event per cycle, up reset lands on zero
    assert_one_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({up_q, dn_q}));
    assert_up_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        up_q |-> (cnt_q == '0));
    // R7: wrap mode ignores the index when no step arrives
    assert_idx_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && mode_i == MODE_WRAP && step_i == STEP_NONE) |=> $stable(cnt_q));

endmodule

// File: rtl/qx4_position.sv
// Top: quadrature X4 position counter built from a configuration shadow,
// a phase decoder and the bounded counter.
module qx4_position
    import qx4_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             swap_ab,
    input  logic             inv_a,
    input  logic             inv_b,
    input  logic             idx_falling,
    input  logic [1:0]       idx_gate,
    input  logic             wrap_mode,
    input  logic [CNT_W-1:0] ceiling,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic             index,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             evt_reset_up,
    output logic             evt_reset_down,
    output logic             evt_dir_change,
    output logic             phase_err
);

    logic             s_swap, s_inv_a, s_inv_b, s_idx_fall;
    logic [1:0]       s_gate;
    rst_mode_e        s_mode;
    logic [CNT_W-1:0] s_ceil;
    step_e            step;
    logic             idx_hit;

    qx4_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .en_i(enable),
        .swap_i(swap_ab), .inv_a_i(inv_a), .inv_b_i(inv_b),
        .idx_fall_i(idx_falling), .gate_i(idx_gate), .mode_i(wrap_mode),
        .ceil_i(ceiling),
        .swap_q(s_swap), .inv_a_q(s_inv_a), .inv_b_q(s_inv_b),
        .idx_fall_q(s_idx_fall), .gate_q(s_gate), .mode_q(s_mode),
        .ceil_q(s_ceil)
    );

    qx4_decode u_dec (
        .clk(clk), .rst_n(rst_n),
        .swap_i(s_swap), .inv_a_i(s_inv_a), .inv_b_i(s_inv_b),
        .idx_fall_i(s_idx_fall), .gate_i(s_gate),
        .pha_i(phase_a), .phb_i(phase_b), .idx_i(index),
        .step_o(step), .idx_hit_o(idx_hit)
    );

    qx4_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en_i(enable),
        .mode_i(s_mode), .ceil_i(s_ceil),
        .step_i(step), .idx_hit_i(idx_hit),
        .count_o(count), .dir_o(dir_up),
        .up_evt_o(evt_reset_up), .dn_evt_o(evt_reset_down),
        .chg_evt_o(evt_dir_change), .err_o(phase_err)
    );

endmodule

// File: tb/tb_qx4_position.sv
// Bench: vector table walk, then directed tests for reset, wrap, swap,
// polarity, index gating, mode and configuration freezing.
module tb_qx4_position;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, swap = 1'b0, ia = 1'b0, ib = 1'b0, ifall = 1'b0;
    logic [1:0]  gate = 2'd0;
    logic        mode = 1'b0;
    logic [31:0] ceil = 32'd1000;
    logic        pa = 1'b0, pb = 1'b0, idx = 1'b0;
    logic [31:0] count;
    logic        dir_up, ev_up, ev_dn, ev_chg, perr;
    int          checks = 0, failures = 0, cyc = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    qx4_position dut (
        .clk(clk), .rst_n(rst_n), .enable(en), .swap_ab(swap),
        .inv_a(ia), .inv_b(ib), .idx_falling(ifall), .idx_gate(gate),
        .wrap_mode(mode), .ceiling(ceil), .phase_a(pa), .phase_b(pb),
        .index(idx), .count(count), .dir_up(dir_up), .evt_reset_up(ev_up),
        .evt_reset_down(ev_dn), .evt_dir_change(ev_chg), .phase_err(perr)
    );

    // Fields: {a, b, dir, up_evt, dn_evt, chg_evt, count}
    localparam logic [37:0] VEC [0:14] = '{
        {6'b10_1000, 32'd1},    {6'b11_1000, 32'd2},    {6'b01_1000, 32'd3},
        {6'b00_1000, 32'd4},    {6'b10_1000, 32'd5},    {6'b00_0001, 32'd4},
        {6'b01_0000, 32'd3},    {6'b11_0000, 32'd2},    {6'b10_0000, 32'd1},
        {6'b00_0000, 32'd0},    {6'b01_0010, 32'd1000}, {6'b00_1101, 32'd0},
        {6'b11_1000, 32'd0},    {6'b01_1000, 32'd1},    {6'b00_1000, 32'd2}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic mv(input logic a, input logic b);
        pa = a; pb = b;
        @(negedge clk);
    endtask

    task automatic reconfig();
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count", count, 0); chk("R1 dir", {31'd0, dir_up}, 1);
        chk("R1 events", {29'd0, ev_up, ev_dn, ev_chg}, 0); chk("R1 err", {31'd0, perr}, 0);

        en = 1'b1;
        for (int i = 0; i < 15; i++) begin
            mv(VEC[i][37], VEC[i][36]);
            chk("R2/R3/R8 count", count, VEC[i][31:0]);
            chk("R9 dir", {31'd0, dir_up}, {31'd0, VEC[i][35]});
            chk("R8 reset_up", {31'd0, ev_up}, {31'd0, VEC[i][34]});
            chk("R8 reset_down", {31'd0, ev_dn}, {31'd0, VEC[i][33]});
            chk("R9 dir_change", {31'd0, ev_chg}, {31'd0, VEC[i][32]});
        end
        chk("R10 sticky err", {31'd0, perr}, 1);

        // Second reset: ceiling 3, stopped
        en = 1'b0; ceil = 32'd3; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        chk("R1 err cleared", {31'd0, perr}, 0);
        mv(1, 0); chk("R11 hold", count, 0);
        mv(1, 1); chk("R11 hold", count, 0); chk("R11 no event", {29'd0, ev_up, ev_dn, ev_chg}, 0);

        en = 1'b1;
        mv(0, 1); chk("R2 count", count, 1);
        mv(0, 0); mv(1, 0); chk("R2 count", count, 3);
        mv(1, 1); chk("R8 wrap", count, 0); chk("R8 up evt", {31'd0, ev_up}, 1);

        ceil = 32'd100;
        mv(0, 1); mv(0, 0); mv(1, 0); chk("R12 count", count, 3);
        mv(1, 1); chk("R12 old ceiling", count, 0); chk("R12 up evt", {31'd0, ev_up}, 1);

        mv(1, 0); chk("R8 down wrap", count, 3); chk("R8 dn evt", {31'd0, ev_dn}, 1);
        chk("R9 chg", {31'd0, ev_chg}, 1); chk("R9 dir", {31'd0, dir_up}, 0);

        swap = 1'b1; reconfig();
        mv(1, 1); chk("R4 swap down", count, 2);

        swap = 1'b0; ia = 1'b1; reconfig();
        mv(1, 0); chk("R5 inv_a up", count, 3); chk("R9 dir up", {31'd0, dir_up}, 1);

        ia = 1'b0; gate = 2'd2; mode = 1'b0; reconfig();
        idx = 1'b1; @(negedge clk);
        chk("R6 gated reset", count, 0); chk("R6 up evt", {31'd0, ev_up}, 1);
        idx = 1'b0; @(negedge clk);
        mv(1, 1); chk("R2 count", count, 1);
        idx = 1'b1; @(negedge clk); chk("R6 wrong phase", count, 1);
        idx = 1'b0; @(negedge clk);

        ifall = 1'b1; gate = 2'd3; reconfig();
        idx = 1'b1; @(negedge clk); chk("R5 rising ignored", count, 1);
        idx = 1'b0; @(negedge clk); chk("R5 falling reset", count, 0);

        ifall = 1'b0; mode = 1'b1; gate = 2'd1; reconfig();
        mv(0, 1); chk("R2 count", count, 1);
        idx = 1'b1; @(negedge clk);
        chk("R7 idx ignored", count, 1); chk("R7 no evt", {30'd0, ev_up, ev_dn}, 0);
        idx = 1'b0; @(negedge clk);

        mv(1, 0); chk("R10 illegal hold", count, 1); chk("R10 err", {31'd0, perr}, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule